// File: doc/BRIEF.md
# Ethernet Transmit Stop and Interrupt Event Unit

This unit sits next to an Ethernet MAC transmitter and does two jobs. The first job is the graceful stop. Three sources can request a stop: a software halt bit, a software pause-frame bit, and a flag from the receiver that a valid full-duplex flow-control pause frame has arrived. On a request, the unit lets the frame that is on the wire finish. It then holds the transmitter in a paused state until every source has withdrawn its request.

The second job is event collection. Single-cycle event strobes from the MAC, from the DMA engines and from the management port are latched into a 32-bit event register. Software clears each bit by writing a 1 to it. A 32-bit mask register selects which events drive the single interrupt line. A bus error also drops the controller-enable bit. Late-collision and retry-limit events count only in half-duplex mode. A small counter turns per-attempt collision strobes into the retry-limit event.

The unit moves no data stream, so it has no valid/ready interface. Every pin is a plain control or status level or strobe. The software writes are single-cycle strobes that carry `sw_wdata`.

Top module: `eth_txstop_irq`

## Requirements
- R1: While `tx_active` is high, `tx_pause` stays low even if a stop is requested. `tx_pause` goes high on the first clock edge at which a stop is requested and `tx_active` is low.
- R2: If a stop is requested while no frame is in flight, `tx_pause` and event bit 28 are both set on the next clock edge.
- R3: Any of `stop_sw`, `pause_sw` or `pause_rx` starts a graceful stop, and each completed stop sets bit 28. The pause is released one edge after all three sources are low. If all sources drop while the unit is still waiting for the frame to end, it returns to running without setting bit 28.
- R4: The event bit layout is: 28 stop complete, 27 transmit frame done, 26 transmit buffer done, 25 receive frame done, 24 receive buffer done, 23 management transfer done, 22 bus error, 21 late collision, 20 retry limit, 19 transmit underrun. Bits 18 to 0 and 31 to 29 always read 0.
- R5: A `sw_clr_evt` strobe clears every event bit whose `sw_wdata` bit is 1. A 0 in `sw_wdata` leaves the bit unchanged. A set and a clear of the same bit in one cycle leave the bit set.
- R6: `irq` is high exactly when some bit is set in both `evt_q` and `mask_q`. The mask is loaded from `sw_wdata` on `sw_wr_mask`.
- R7: A `bus_err` strobe sets bit 22 and clears `ctl_en` on the same edge, even if a `sw_wr_ctl` write arrives in that cycle. Only a later `sw_wr_ctl` write with `sw_wdata[0]`=1 sets `ctl_en` again.
- R8: When `full_duplex` is high, `late_col` and `coll_retry` strobes change nothing: bit 21 and bit 20 are not set, and the collision count returns to zero.
- R9: In half-duplex mode, bit 20 is set on the 16th consecutive `coll_retry` strobe. The count then restarts. A `tx_frame_done` strobe resets the count to zero.
- R10: Each of the strobes `tx_frame_done`, `tx_buf_done`, `rx_frame_done`, `rx_buf_done`, `mii_done` and `tx_underrun` sets its bit from R4 one edge after it is sampled.
- R11: After reset, `evt_q`, `mask_q`, `ctl_en`, `tx_pause` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stop_sw | input | 1 | Software halt request (level) |
| pause_sw | input | 1 | Software pause-frame request (level) |
| pause_rx | input | 1 | Received pause frame in effect (level) |
| tx_active | input | 1 | A frame is currently being transmitted |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| tx_frame_done | input | 1 | Transmit frame completed strobe |
| tx_buf_done | input | 1 | Transmit buffer descriptor updated strobe |
| rx_frame_done | input | 1 | Receive frame completed strobe |
| rx_buf_done | input | 1 | Receive buffer (not last) updated strobe |
| mii_done | input | 1 | Management transfer completed strobe |
| bus_err | input | 1 | System bus error strobe |
| late_col | input | 1 | Late collision strobe |
| coll_retry | input | 1 | One transmit attempt ended in collision |
| tx_underrun | input | 1 | Transmit FIFO underrun strobe |
| sw_wdata | input | 32 | Software write data |
| sw_clr_evt | input | 1 | Write-1-to-clear strobe for the event register |
| sw_wr_mask | input | 1 | Load strobe for the mask register |
| sw_wr_ctl | input | 1 | Write strobe for the controller enable (`sw_wdata[0]`) |
| evt_q | output | 32 | Event register |
| mask_q | output | 32 | Mask register |
| irq | output | 1 | Combined interrupt |
| tx_pause | output | 1 | Transmitter held paused |
| ctl_en | output | 1 | Controller enable |

## Verification
Every result except `irq` appears exactly one clock edge after the stimulus that causes it. Event bits, `ctl_en`, `tx_pause` and the mask all change on the edge that samples their strobe or request. `irq` follows the registers in the same cycle, with no delay of its own. The bench drives inputs on the falling edge. A behavioural model is updated on the rising edge from the same inputs. All outputs are compared with the model on the next falling edge, so each result is checked in the cycle it is due. Directed checks also sample the multi-cycle cases at fixed cycle counts: the stop that waits for the frame to end, and the 16-strike retry count.

// File: rtl/eth_txstop_irq_pkg.sv
package eth_txstop_irq_pkg;
  localparam int EVW = 32;
  localparam int EV_GSTOP   = 28;
  localparam int EV_TXF     = 27;
  localparam int EV_TXB     = 26;
  localparam int EV_RXF     = 25;
  localparam int EV_RXB     = 24;
  localparam int EV_MGMT    = 23;
  localparam int EV_BUSERR  = 22;
  localparam int EV_LATECOL = 21;
  localparam int EV_RETRY   = 20;
  localparam int EV_UNDER   = 19;
  localparam logic [EVW-1:0] EV_USED = 32'h1FF8_0000;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_HALT  = 2'd2
  } stop_state_e;
endpackage

// File: rtl/txstop_seq.sv
module txstop_seq #(
  parameter int N_SRC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] stop_req,
  input  logic             tx_active,
  output logic             tx_pause,
  output logic             done_pulse
);
  import eth_txstop_irq_pkg::*;

  stop_state_e state_q, state_d;
  logic any_req;

  assign any_req = |stop_req;

  always_comb begin
    state_d    = state_q;
    done_pulse = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (any_req && tx_active) begin
          state_d = ST_DRAIN;
        end else if (any_req) begin
          state_d    = ST_HALT;
          done_pulse = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (!any_req) begin
          state_d = ST_RUN;
        end else if (!tx_active) begin
          state_d    = ST_HALT;
          done_pulse = 1'b1;
        end
      end
      ST_HALT: begin
        if (!any_req) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign tx_pause = (state_q == ST_HALT);
endmodule

// File: rtl/retry_cnt.sv
module retry_cnt #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic half_dup,
  input  logic coll,
  input  logic frame_end,
  output logic limit_hit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign limit_hit = half_dup && coll && !frame_end && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !half_dup || frame_end || limit_hit) cnt_q <= '0;
    else if (coll)                                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/evt_reg.sv
module evt_reg #(
  parameter int              W    = 32,
  parameter logic [W-1:0]    USED = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] evt_q,
  output logic [W-1:0] mask_q,
  output logic         irq
);
  logic [W-1:0] clr_vec;

  assign clr_vec = clr_we ? wdata : '0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (USED[i]) begin : g_live
      always_ff @(posedge clk) begin
        if (!rst_n)          evt_q[i] <= 1'b0;
        else if (set_vec[i]) evt_q[i] <= 1'b1;
        else if (clr_vec[i]) evt_q[i] <= 1'b0;
      end
    end else begin : g_tied
      assign evt_q[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= wdata;
  end

  assign irq = |(evt_q & mask_q);
endmodule

// File: rtl/eth_txstop_irq.sv
module eth_txstop_irq
  import eth_txstop_irq_pkg::*;
#(
  parameter int RETRY_LIMIT = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stop_sw,
  input  logic           pause_sw,
  input  logic           pause_rx,
  input  logic           tx_active,
  input  logic           full_duplex,
  input  logic           tx_frame_done,
  input  logic           tx_buf_done,
  input  logic           rx_frame_done,
  input  logic           rx_buf_done,
  input  logic           mii_done,
  input  logic           bus_err,
  input  logic           late_col,
  input  logic           coll_retry,
  input  logic           tx_underrun,
  input  logic [EVW-1:0] sw_wdata,
  input  logic           sw_clr_evt,
  input  logic           sw_wr_mask,
  input  logic           sw_wr_ctl,
  output logic [EVW-1:0] evt_q,
  output logic [EVW-1:0] mask_q,
  output logic           irq,
  output logic           tx_pause,
  output logic           ctl_en
);
  logic           gstop_done;
  logic           retry_hit;
  logic           half_dup;
  logic [EVW-1:0] set_vec;

  assign half_dup = !full_duplex;

  txstop_seq #(.N_SRC(3)) u_stop (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_req  ({pause_rx, pause_sw, stop_sw}),
    .tx_active (tx_active),
    .tx_pause  (tx_pause),
    .done_pulse(gstop_done)
  );

  retry_cnt #(.LIMIT(RETRY_LIMIT)) u_retry (
    .clk      (clk),
    .rst_n    (rst_n),
    .half_dup (half_dup),
    .coll     (coll_retry),
    .frame_end(tx_frame_done),
    .limit_hit(retry_hit)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[EV_GSTOP]   = gstop_done;
    set_vec[EV_TXF]     = tx_frame_done;
    set_vec[EV_TXB]     = tx_buf_done;
    set_vec[EV_RXF]     = rx_frame_done;
    set_vec[EV_RXB]     = rx_buf_done;
    set_vec[EV_MGMT]    = mii_done;
    set_vec[EV_BUSERR]  = bus_err;
    set_vec[EV_LATECOL] = late_col && half_dup;
    set_vec[EV_RETRY]   = retry_hit;
    set_vec[EV_UNDER]   = tx_underrun;
  end

  evt_reg #(.W(EVW), .USED(EV_USED)) u_evt (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(set_vec),
    .clr_we (sw_clr_evt),
    .mask_we(sw_wr_mask),
    .wdata  (sw_wdata),
    .evt_q  (evt_q),
    .mask_q (mask_q),
    .irq    (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         ctl_en <= 1'b0;
    else if (bus_err)   ctl_en <= 1'b0;
    else if (sw_wr_ctl) ctl_en <= sw_wdata[0];
  end
endmodule

// File: rtl/eth_txstop_irq_chk.sv
module eth_txstop_irq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        stop_sw,
  input logic        pause_sw,
  input logic        pause_rx,
  input logic        tx_active,
  input logic        full_duplex,
  input logic        tx_frame_done,
  input logic        bus_err,
  input logic        late_col,
  input logic [31:0] evt_q,
  input logic        tx_pause,
  input logic        ctl_en
);
  logic any_stop;
  assign any_stop = stop_sw | pause_sw | pause_rx;

  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q[18:0] == '0) && (evt_q[31:29] == '0));

  assert_busy_no_pause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && !tx_pause) |=> !tx_pause);

  assert_idle_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (any_stop && !tx_active) |=> tx_pause);

  assert_pause_sets_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_pause) |-> evt_q[28]);

  assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_stop && tx_pause) |=> !tx_pause);

  assert_frame_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_frame_done |=> evt_q[27]);

  assert_buserr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> (!ctl_en && evt_q[22]));

  assert_fd_latecol_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full_duplex && late_col && !evt_q[21]) |=> !evt_q[21]);
endmodule

bind eth_txstop_irq eth_txstop_irq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stop_sw      (stop_sw),
  .pause_sw     (pause_sw),
  .pause_rx     (pause_rx),
  .tx_active    (tx_active),
  .full_duplex  (full_duplex),
  .tx_frame_done(tx_frame_done),
  .bus_err      (bus_err),
  .late_col     (late_col),
  .evt_q        (evt_q),
  .tx_pause     (tx_pause),
  .ctl_en       (ctl_en)
);

// File: tb/eth_txstop_irq_tb.sv
module eth_txstop_irq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_sw = 0, pause_sw = 0, pause_rx = 0, tx_active = 0, full_duplex = 0;
  logic tx_frame_done = 0, tx_buf_done = 0, rx_frame_done = 0, rx_buf_done = 0;
  logic mii_done = 0, bus_err = 0, late_col = 0, coll_retry = 0, tx_underrun = 0;
  logic [31:0] sw_wdata = '0;
  logic sw_clr_evt = 0, sw_wr_mask = 0, sw_wr_ctl = 0;
  logic [31:0] evt_q, mask_q;
  logic irq, tx_pause, ctl_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_txstop_irq u_dut (
    .clk(clk), .rst_n(rst_n), .stop_sw(stop_sw), .pause_sw(pause_sw), .pause_rx(pause_rx),
    .tx_active(tx_active), .full_duplex(full_duplex), .tx_frame_done(tx_frame_done),
    .tx_buf_done(tx_buf_done), .rx_frame_done(rx_frame_done), .rx_buf_done(rx_buf_done),
    .mii_done(mii_done), .bus_err(bus_err), .late_col(late_col), .coll_retry(coll_retry),
    .tx_underrun(tx_underrun), .sw_wdata(sw_wdata), .sw_clr_evt(sw_clr_evt),
    .sw_wr_mask(sw_wr_mask), .sw_wr_ctl(sw_wr_ctl), .evt_q(evt_q), .mask_q(mask_q),
    .irq(irq), .tx_pause(tx_pause), .ctl_en(ctl_en)
  );

  // behavioural reference model
  int          m_mode;      // 0 running, 1 waiting for frame end, 2 paused
  logic [31:0] m_evt, m_mask;
  bit          m_en;
  int          m_strikes;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_evt = 0; m_mask = 0; m_en = 0; m_strikes = 0;
    end else begin
      automatic logic [31:0] s = 0;
      automatic bit want = stop_sw || pause_sw || pause_rx;
      if (m_mode == 2) begin
        if (!want) m_mode = 0;
      end else if (!want) begin
        m_mode = 0;
      end else if (tx_active) begin
        m_mode = 1;
      end else begin
        m_mode = 2; s[28] = 1;
      end
      if (tx_frame_done) s[27] = 1;
      if (tx_buf_done)   s[26] = 1;
      if (rx_frame_done) s[25] = 1;
      if (rx_buf_done)   s[24] = 1;
      if (mii_done)      s[23] = 1;
      if (bus_err)       s[22] = 1;
      if (late_col && !full_duplex) s[21] = 1;
      if (tx_underrun)   s[19] = 1;
      if (full_duplex || tx_frame_done) m_strikes = 0;
      else if (coll_retry) begin
        m_strikes++;
        if (m_strikes == 16) begin s[20] = 1; m_strikes = 0; end
      end
      if (sw_clr_evt) m_evt = m_evt & ~sw_wdata;
      m_evt = m_evt | s;
      if (sw_wr_mask) m_mask = sw_wdata;
      if (bus_err) m_en = 0;
      else if (sw_wr_ctl) m_en = sw_wdata[0];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(evt_q === m_evt, "R4 R5 R10 evt_q", evt_q, m_evt);
      chk(mask_q === m_mask, "R6 mask_q", mask_q, m_mask);
      chk(irq === |(m_evt & m_mask), "R6 irq", {31'd0, irq}, {31'd0, |(m_evt & m_mask)});
      chk(tx_pause === (m_mode == 2), "R1 R2 R3 tx_pause", {31'd0, tx_pause}, {31'd0, m_mode == 2});
      chk(ctl_en === m_en, "R7 ctl_en", {31'd0, ctl_en}, {31'd0, m_en});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_evt(input logic [31:0] d);
    sw_wdata = d; sw_clr_evt = 1; cyc(1); sw_clr_evt = 0; sw_wdata = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(evt_q === 0 && mask_q === 0 && !irq && !tx_pause && !ctl_en, "R11 reset",
        {evt_q[31:4], irq, tx_pause, ctl_en, 1'b0}, 32'd0);

    // enable and mask
    sw_wdata = 32'h1; sw_wr_ctl = 1; cyc(1); sw_wr_ctl = 0;
    sw_wdata = 32'h0808_0000; sw_wr_mask = 1; cyc(1); sw_wr_mask = 0; sw_wdata = 0;

    // R10 individual strobes
    tx_buf_done = 1; cyc(1); tx_buf_done = 0;
    chk(evt_q[26] && !irq, "R10 txb", evt_q, 32'h0400_0000);
    rx_frame_done = 1; rx_buf_done = 1; mii_done = 1; cyc(1);
    rx_frame_done = 0; rx_buf_done = 0; mii_done = 0;
    chk(evt_q === 32'h0780_0000, "R10 rx/mgmt", evt_q, 32'h0780_0000);
    tx_underrun = 1; cyc(1); tx_underrun = 0;
    chk(irq === 1'b1, "R6 irq underrun", {31'd0, irq}, 32'd1);

    // R5 write-0 no effect, write-1 clears
    clr_evt(32'h0);
    chk(evt_q === 32'h0788_0000, "R5 zero write", evt_q, 32'h0788_0000);
    clr_evt(32'hFFFF_FFFF);
    chk(evt_q === 0 && !irq, "R5 clear all", evt_q, 0);
    // set wins over clear
    tx_frame_done = 1; sw_wdata = 32'h0800_0000; sw_clr_evt = 1; cyc(1);
    tx_frame_done = 0; sw_clr_evt = 0; sw_wdata = 0;
    chk(evt_q[27] === 1'b1, "R5 set wins", evt_q, 32'h0800_0000);
    clr_evt(32'h0800_0000);

    // R7 bus error beats a same-cycle write
    bus_err = 1; sw_wdata = 1; sw_wr_ctl = 1; cyc(1);
    bus_err = 0; sw_wr_ctl = 0; sw_wdata = 0;
    chk(!ctl_en && evt_q[22], "R7 bus error", {31'd0, ctl_en}, 32'd0);
    cyc(3);
    chk(!ctl_en, "R7 stays off", {31'd0, ctl_en}, 32'd0);
    sw_wdata = 1; sw_wr_ctl = 1; cyc(1); sw_wr_ctl = 0; sw_wdata = 0;
    chk(ctl_en === 1'b1, "R7 re-enable", {31'd0, ctl_en}, 32'd1);
    clr_evt(32'hFFFF_FFFF);

    // R8 full duplex ignores collisions
    full_duplex = 1; late_col = 1; coll_retry = 1;
    cyc(20);
    late_col = 0; coll_retry = 0;
    chk(evt_q[21:20] === 2'b00, "R8 full duplex", evt_q, 0);
    full_duplex = 0;
    late_col = 1; cyc(1); late_col = 0;
    chk(evt_q[21] === 1'b1, "R8 half duplex late", evt_q, 32'h0020_0000);

    // R9 retry limit: 15 strikes, frame done, then 16
    coll_retry = 1; cyc(15); coll_retry = 0;
    tx_frame_done = 1; cyc(1); tx_frame_done = 0;
    coll_retry = 1; cyc(15);
    chk(evt_q[20] === 1'b0, "R9 fifteen", evt_q, 0);
    cyc(1); coll_retry = 0;
    chk(evt_q[20] === 1'b1, "R9 sixteenth", evt_q, 32'h0010_0000);
    clr_evt(32'hFFFF_FFFF);

    // R1 stop waits for frame end
    tx_active = 1; stop_sw = 1; cyc(5);
    chk(!tx_pause && !evt_q[28], "R1 busy", {31'd0, tx_pause}, 0);
    tx_active = 0; cyc(1);
    chk(tx_pause && evt_q[28], "R1 after frame", {31'd0, tx_pause}, 1);
    // R3 overlapping sources
    pause_rx = 1; cyc(1); stop_sw = 0; cyc(2);
    chk(tx_pause === 1'b1, "R3 one source left", {31'd0, tx_pause}, 1);
    pause_rx = 0; cyc(1);
    chk(tx_pause === 1'b0, "R3 released", {31'd0, tx_pause}, 0);
    clr_evt(32'hFFFF_FFFF);
    // R3 withdrawal during drain gives no completion
    tx_active = 1; pause_sw = 1; cyc(2); pause_sw = 0; cyc(1); tx_active = 0; cyc(2);
    chk(!tx_pause && !evt_q[28], "R3 withdrawn", evt_q, 0);
    // R2 idle stop
    pause_sw = 1; cyc(1);
    chk(tx_pause && evt_q[28], "R2 idle stop", evt_q, 32'h1000_0000);
    pause_sw = 0; cyc(2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule